// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block is the interrupt concentrator for a small shared-memory multiprocessor with up to four CPUs. System device lines are level-sensitive. They are gated by a system mask that has a global mask-all bit. The mask is changed through separate write-one-to-set and write-one-to-clear ports, and a set mask bit disables its source. Each CPU also owns a soft pending register. Any bus master may set a bit in it, which is how one CPU sends an inter-processor interrupt to another.

Each CPU receives a registered 4-bit priority level. The level is the highest level among that CPU's soft interrupts and its profiling-timer line. When the CPU is the current undirected target, the unmasked system interrupts are also included. A single 32-bit register bus with word addresses gives access to every register. Reads are combinational and carry no side effects.

Address map (word addresses): CPU c uses 4c (pending, read), 4c+1 (clear port), 4c+2 (set port). The system registers are 16 (raw line state), 17 (mask readback), 18 (mask clear port), 19 (mask set port) and 20 (target, read/write).

Top module: `irq_mask_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all 32 system mask bits read as ones at word 17, including mask-all bit 31. Every CPU soft pending register reads zero, the target at word 20 reads 0, and every level output is 0.
- R2: A write to word 19 sets each mask bit where the data bit is one. Zero data bits leave the mask unchanged.
- R3: A write to word 18 clears each mask bit where the data bit is one. Zero data bits leave the mask unchanged.
- R4: While mask bit 31 is set, no system line raises any CPU's level, whatever the per-bit mask holds.
- R5: A read of word 16 returns the present raw state of system lines 30:0, whether masked or not. Bit 31 reads zero.
- R6: For CPU c, a write to word 4c+2 sets soft pending bits 31:17, and a write to word 4c+1 clears them. Soft level n (1 to 15) is bit 16+n. Zero data bits have no effect, and any write to one CPU's ports leaves the other CPUs untouched.
- R7: A read of word 4c returns soft pending in bits 31:17 and CPU c's profiling line in bit 14. All other bits are zero.
- R8: An unmasked system line raises the following level. Line k in 0..6, and line 7+k, give level 2 when k=0 and level 2k+1 otherwise. Line 14 gives 12, 15 gives 12, 16 gives 6, 17 gives 13, 18 gives 4, 19 gives 10, 20 gives 8, 22 gives 11 and 30 gives 9. Lines 21, 23 to 29 raise no level.
- R9: Only the CPU whose index is held in the read/write target register at word 20 sees system interrupts.
- R10: Each level output is the highest pending level (0 when none). It is registered and follows a state or input change at the next clock edge.
- R11: A read of any write-only port or unmapped word returns zero and changes no state.
- R12: System lines are not latched. When a line drops, its contribution is gone at the next edge.
- R13: CPU c's profiling line raises level 14 on that CPU only, independent of the system mask and target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read is selected |
| sys_irq_i | input | 31 | Level-sensitive system device lines |
| prof_irq_i | input | NUM_CPU | Per-CPU profiling timer lines |
| cpu_level_o | output | 4*NUM_CPU | Per-CPU priority level, CPU c in bits 4c+3:4c |

## Verification
A corrupted mask or soft bit shows up one edge later. Depending on the corruption, a CPU level is then too high, too low or wrongly zero, and the mask or pending readback word differs at once on the next read. A stale or wrong target register moves system levels onto the wrong CPU output on the next edge. For that reason every system line, every soft level on every CPU and every target value is swept, and the level is compared one cycle after each change.

// File: rtl/imc_pkg.sv
// imc_pkg: shared constants and the system-line-to-level mapping for the
// interrupt mask controller. Assumes the 5-bit word address map of the brief.
package imc_pkg;

    localparam int DATA_W       = 32;
    localparam int SYS_W        = 31;
    localparam int LVL_W        = 4;
    localparam int NUM_LVL      = 16;
    localparam int SOFT_W       = 15;
    localparam int SOFT_LSB     = 17;
    localparam int PROF_BIT     = 14;
    localparam int MASK_ALL_BIT = 31;
    localparam int ADDR_W       = 5;

    // Word offsets
    localparam logic [1:0] OFF_PEND = 2'd0;
    localparam logic [1:0] OFF_CLR  = 2'd1;
    localparam logic [1:0] OFF_SET  = 2'd2;
    localparam logic [ADDR_W-1:0] A_RAW  = 5'd16;
    localparam logic [ADDR_W-1:0] A_MASK = 5'd17;
    localparam logic [ADDR_W-1:0] A_MCLR = 5'd18;
    localparam logic [ADDR_W-1:0] A_MSET = 5'd19;
    localparam logic [ADDR_W-1:0] A_TGT  = 5'd20;

    // Level raised by system line b; 0 means the line raises nothing.
    function automatic logic [LVL_W-1:0] line_level(input int b);
        int k;
        k = (b < 7) ? b : b - 7;
        if (b <= 13) begin
            return (k == 0) ? LVL_W'(2) : LVL_W'(2 * k + 1);
        end
        case (b)
            14, 15:  return LVL_W'(12);
            16:      return LVL_W'(6);
            17:      return LVL_W'(13);
            18:      return LVL_W'(4);
            19:      return LVL_W'(10);
            20:      return LVL_W'(8);
            22:      return LVL_W'(11);
            30:      return LVL_W'(9);
            default: return LVL_W'(0);
        endcase
    endfunction

    // One-hot-per-level request vector from the active system lines.
    function automatic logic [NUM_LVL-1:0] sys_level_vec(input logic [SYS_W-1:0] act);
        logic [NUM_LVL-1:0] v;
        v = '0;
        for (int b = 0; b < SYS_W; b++) begin
            if (act[b] && line_level(b) != '0) begin
                v[line_level(b)] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/imc_sys_mask.sv
// imc_sys_mask: holds the 32-bit system mask (bit 31 = mask-all) and the
// undirected target index. Assumes set and clear strobes are never both high.
module imc_sys_mask #(
    parameter int DATA_W = 32,
    parameter int TGT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_tgt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TGT_W-1:0]  tgt_wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [TGT_W-1:0]  target_q
);

    // Mask: write-one set disables, write-one clear enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_set) begin
            mask_q <= mask_q | wdata;
        end else if (wr_clr) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    // Target register for undirected interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (wr_tgt) begin
            target_q <= tgt_wdata;
        end
    end

endmodule

// File: rtl/imc_soft_pend.sv
// imc_soft_pend: one CPU's soft pending register, levels 1..SOFT_W in bits
// 0..SOFT_W-1. Assumes set and clear strobes are mutually exclusive.
module imc_soft_pend #(
    parameter int SOFT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [SOFT_W-1:0] wdata,
    output logic [SOFT_W-1:0] soft_q
);

    // Write-one set / write-one clear of pending soft levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else if (wr_set) begin
            soft_q <= soft_q | wdata;
        end else if (wr_clr) begin
            soft_q <= soft_q & ~wdata;
        end
    end

endmodule

// File: rtl/imc_level_enc.sv
// imc_level_enc: registered highest-set-index encoder over a per-level request
// vector. Bit 0 of the vector is ignored; output 0 means nothing pending.
module imc_level_enc #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_vec,
    output logic [LVL_W-1:0]   level_q
);

    logic [LVL_W-1:0] best;

    // Pick the highest requested level.
    always_comb begin
        best = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (req_vec[i]) begin
                best = LVL_W'(i);
            end
        end
    end

    // Register the encoded level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= best;
        end
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
// irq_mask_ctrl: multiprocessor interrupt mask controller top. Decodes the
// word-addressed register bus, keeps the system mask, target and per-CPU soft
// pending registers, and drives a registered priority level per CPU.
// Assumes NUM_CPU <= 4 (the CPU windows occupy words 0..15).
module irq_mask_ctrl
    import imc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int TGT_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel_i,
    input  logic                     bus_we_i,
    input  logic [4:0]               bus_addr_i,
    input  logic [31:0]              bus_wdata_i,
    output logic [31:0]              bus_rdata_o,
    input  logic [30:0]              sys_irq_i,
    input  logic [NUM_CPU-1:0]       prof_irq_i,
    output logic [NUM_CPU*4-1:0]     cpu_level_o
);

    logic                            wr_en;
    logic                            rd_en;
    logic                            in_cpu_win;
    logic [1:0]                      cpu_idx;
    logic [1:0]                      cpu_off;
    logic [DATA_W-1:0]               mask_q;
    logic [TGT_W-1:0]                target_q;
    logic [NUM_CPU-1:0][SOFT_W-1:0]  soft_q;
    logic [SYS_W-1:0]                sys_act;
    logic [NUM_LVL-1:0]              sys_vec;

    assign wr_en      = bus_sel_i && bus_we_i;
    assign rd_en      = bus_sel_i && !bus_we_i;
    assign in_cpu_win = !bus_addr_i[4];
    assign cpu_idx    = bus_addr_i[3:2];
    assign cpu_off    = bus_addr_i[1:0];

    // System mask and target storage.
    imc_sys_mask #(
        .DATA_W (DATA_W),
        .TGT_W  (TGT_W)
    ) u_sys_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_set    (wr_en && bus_addr_i == A_MSET),
        .wr_clr    (wr_en && bus_addr_i == A_MCLR),
        .wr_tgt    (wr_en && bus_addr_i == A_TGT),
        .wdata     (bus_wdata_i),
        .tgt_wdata (bus_wdata_i[TGT_W-1:0]),
        .mask_q    (mask_q),
        .target_q  (target_q)
    );

    // Active system lines: unmasked and not globally blocked.
    always_comb begin
        sys_act = sys_irq_i & ~mask_q[SYS_W-1:0] & {SYS_W{~mask_q[MASK_ALL_BIT]}};
        sys_vec = sys_level_vec(sys_act);
    end

    // Per-CPU soft pending registers and level encoders.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic               hit;
        logic [NUM_LVL-1:0] req;

        assign hit = wr_en && in_cpu_win && (cpu_idx == 2'(c));

        imc_soft_pend #(
            .SOFT_W (SOFT_W)
        ) u_soft (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_set (hit && cpu_off == OFF_SET),
            .wr_clr (hit && cpu_off == OFF_CLR),
            .wdata  (bus_wdata_i[DATA_W-1:SOFT_LSB]),
            .soft_q (soft_q[c])
        );

        // Gather this CPU's requests: soft, profiling, steered system.
        always_comb begin
            req = {soft_q[c], 1'b0};
            req[PROF_BIT] = req[PROF_BIT] | prof_irq_i[c];
            if (target_q == TGT_W'(c)) begin
                req = req | sys_vec;
            end
        end

        imc_level_enc #(
            .NUM_LVL (NUM_LVL),
            .LVL_W   (LVL_W)
        ) u_enc (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_vec (req),
            .level_q (cpu_level_o[c*LVL_W +: LVL_W])
        );
    end

    // Read multiplexer; write-only and unmapped words read zero.
    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            if (in_cpu_win) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (cpu_idx == 2'(c) && cpu_off == OFF_PEND) begin
                        bus_rdata_o = {soft_q[c], 2'b00, prof_irq_i[c], 14'd0};
                    end
                end
            end else begin
                case (bus_addr_i)
                    A_RAW:   bus_rdata_o = {1'b0, sys_irq_i};
                    A_MASK:  bus_rdata_o = mask_q;
                    A_TGT:   bus_rdata_o = {{(DATA_W-TGT_W){1'b0}}, target_q};
                    default: bus_rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// irq_mask_ctrl_chk: temporal checks on the mask controller, bound to the top.
module irq_mask_ctrl_chk #(
    parameter int NUM_CPU = 4,
    parameter int TGT_W   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel_i,
    input logic                       bus_we_i,
    input logic [4:0]                 bus_addr_i,
    input logic [31:0]                bus_wdata_i,
    input logic [31:0]                bus_rdata_o,
    input logic [NUM_CPU-1:0]         prof_irq_i,
    input logic [NUM_CPU*4-1:0]       cpu_level_o,
    input logic [31:0]                mask_q,
    input logic [TGT_W-1:0]           target_q,
    input logic [NUM_CPU-1:0][14:0]   soft_q
);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && bus_addr_i == 5'd19)
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && bus_addr_i == 5'd18)
        |=> ((mask_q & $past(bus_wdata_i)) == 32'd0)); // R3

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i &&
         ((!bus_addr_i[4] && bus_addr_i[1:0] != 2'd0) ||
          bus_addr_i == 5'd18 || bus_addr_i == 5'd19))
        |-> (bus_rdata_o == 32'd0)); // R11

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        AST_MASKALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[31] && soft_q[c] == '0 && !prof_irq_i[c])
            |=> (cpu_level_o[c*4 +: 4] == 4'd0)); // R4

        AST_NONTARGET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (target_q != TGT_W'(c) && soft_q[c] == '0 && !prof_irq_i[c])
            |=> (cpu_level_o[c*4 +: 4] == 4'd0)); // R9

        AST_SOFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            soft_q[c][14] |=> (cpu_level_o[c*4 +: 4] == 4'd15)); // R10

        AST_PROF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            prof_irq_i[c] |=> (cpu_level_o[c*4 +: 4] >= 4'd14)); // R13

        AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel_i && bus_we_i && bus_addr_i == 5'(c*4 + 2))
            |=> ((soft_q[c] & $past(bus_wdata_i[31:17])) == $past(bus_wdata_i[31:17]))); // R6
    end

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .NUM_CPU (NUM_CPU),
    .TGT_W   (TGT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .prof_irq_i  (prof_irq_i),
    .cpu_level_o (cpu_level_o),
    .mask_q      (mask_q),
    .target_q    (target_q),
    .soft_q      (soft_q)
);

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [30:0]   sys_irq = '0;
    logic [NC-1:0] prof = '0;
    logic [NC*4-1:0] lvl;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    irq_mask_ctrl #(.NUM_CPU(NC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .sys_irq_i   (sys_irq),
        .prof_irq_i  (prof),
        .cpu_level_o (lvl)
    );

    // Level expected from system line b, per the requirement table.
    function automatic int exp_line(int b);
        case (b)
            0, 7:   return 2;
            1, 8:   return 3;
            2, 9:   return 5;
            3, 10:  return 7;
            4, 11:  return 9;
            5, 12:  return 11;
            6, 13:  return 13;
            14, 15: return 12;
            16:     return 6;
            17:     return 13;
            18:     return 4;
            19:     return 10;
            20:     return 8;
            22:     return 11;
            30:     return 9;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_max(logic [30:0] act);
        int m = 0;
        for (int b = 0; b < 31; b++) if (act[b] && exp_line(b) > m) m = exp_line(b);
        return m;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    function automatic logic [3:0] lv(int c);
        return lvl[c*4 +: 4];
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        rd(5'd17, d); check("R1 mask", d, 32'hFFFF_FFFF);
        rd(5'd20, d); check("R1 target", d, 0);
        for (int c = 0; c < NC; c++) begin
            rd(5'(4*c), d); check("R1 pend", d, 0);
        end
        check("R1 levels", 32'(lvl), 0);

        // R4 mask-all blocks even with per-bit mask open
        sys_irq = '1;
        settle(); check("R4 all masked", 32'(lvl), 0);
        wr(5'd18, 32'h7FFF_FFFF);
        settle(); check("R4 mask-all only", 32'(lvl), 0);
        rd(5'd17, d); check("R3 clear ones", d, 32'h8000_0000);
        wr(5'd19, 32'h0); rd(5'd17, d); check("R2 zero bits no effect", d, 32'h8000_0000);
        wr(5'd18, 32'h0); rd(5'd17, d); check("R3 zero bits no effect", d, 32'h8000_0000);
        rd(5'd16, d); check("R5 raw all", d, 32'h7FFF_FFFF);
        wr(5'd18, 32'h8000_0000);
        settle();
        check("R8 all lines", 32'(lv(0)), exp_max('1));
        check("R9 others quiet", 32'(lvl[NC*4-1:4]), 0);

        // R8/R5 sweep each line alone
        for (int b = 0; b < 31; b++) begin
            sys_irq = 31'(1) << b;
            settle();
            check($sformatf("R8 line %0d", b), 32'(lv(0)), exp_line(b));
            rd(5'd16, d); check("R5 raw", d, 32'(1) << b);
        end

        // R2 per-bit mask: all lines high, only line b unmasked
        sys_irq = '1;
        for (int b = 0; b < 31; b++) begin
            wr(5'd19, 32'h7FFF_FFFF);
            wr(5'd18, 32'(1) << b);
            settle();
            check($sformatf("R2 only line %0d", b), 32'(lv(0)), exp_line(b));
        end
        wr(5'd18, 32'hFFFF_FFFF);

        // R12 level-sensitive
        sys_irq = 31'(1) << 19; settle(); check("R12 on", 32'(lv(0)), 10);
        sys_irq = '0; settle(); check("R12 off", 32'(lv(0)), 0);

        // R9 steering sweep
        sys_irq = 31'(1) << 19;
        for (int t = 0; t < NC; t++) begin
            wr(5'd20, 32'(t));
            rd(5'd20, d); check("R9 target read", d, t);
            settle();
            for (int c = 0; c < NC; c++)
                check($sformatf("R9 cpu%0d tgt%0d", c, t), 32'(lv(c)), (c == t) ? 10 : 0);
        end
        wr(5'd20, 32'd0);
        sys_irq = '0;

        // R6/R7/R10 soft levels per CPU, ascending set then descending clear
        for (int c = 0; c < NC; c++) begin
            for (int n = 1; n < 16; n++) begin
                wr(5'(4*c+2), 32'(1) << (16+n));
                settle();
                check($sformatf("R10 cpu%0d set%0d", c, n), 32'(lv(c)), n);
            end
            rd(5'(4*c), d); check("R7 pend all", d, 32'hFFFE_0000);
            for (int o = 0; o < NC; o++) if (o != c) begin
                rd(5'(4*o), d); check("R6 other cpu untouched", d, 0);
            end
            wr(5'(4*c+2), 32'h0001_FFFF);
            rd(5'(4*c), d); check("R6 low bits no effect", d, 32'hFFFE_0000);
            for (int n = 15; n >= 1; n--) begin
                wr(5'(4*c+1), 32'(1) << (16+n));
                settle();
                check($sformatf("R6 cpu%0d clr%0d", c, n), 32'(lv(c)), n-1);
            end
        end

        // R10 soft combined with system
        sys_irq = 31'(1) << 19;
        wr(5'd2, 32'(1) << 19); settle(); check("R10 soft3+sys10", 32'(lv(0)), 10);
        wr(5'd2, 32'(1) << 28); settle(); check("R10 soft12+sys10", 32'(lv(0)), 12);
        wr(5'd1, 32'hFFFF_FFFF); sys_irq = '0;

        // R13 profiling line, independent of mask
        wr(5'd19, 32'hFFFF_FFFF);
        prof = 4'b0010; settle();
        check("R13 cpu1", 32'(lv(1)), 14);
        check("R13 cpu0 quiet", 32'(lv(0)), 0);
        rd(5'd4, d); check("R7 prof bit", d, 32'h0000_4000);
        prof = '0;

        // R11 write-only / unmapped reads
        wr(5'd18, 32'h0000_00F0);
        rd(5'd1, d);  check("R11 cpu clr read", d, 0);
        rd(5'd2, d);  check("R11 cpu set read", d, 0);
        rd(5'd18, d); check("R11 mask clr read", d, 0);
        rd(5'd19, d); check("R11 mask set read", d, 0);
        rd(5'd21, d); check("R11 unmapped", d, 0);
        rd(5'd17, d); check("R11 mask unchanged", d, 32'hFFFF_FF0F);
        rd(5'd0, d);  check("R11 pend unchanged", d, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule